// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM

This block is a two-port word memory for on-chip storage in the style of an FPGA block RAM. Each port carries one request per cycle: a request flag, a lane-enable vector, an address and a write word, and it has a read-data output that is always valid. The lane-enable vector alone chooses the operation. When it is all zero the request is a read. When it is nonzero the request writes only the enabled byte lanes. There is no ready or valid handshake. A request is taken in every cycle its flag is high, and the caller must capture the read data in the cycle the configured latency dictates.

Ports A and B are independent, and each has its own clock and active-low asynchronous reset. The `OUT_REG` parameter adds a second register after the captured read word, which moves the read latency from one cycle to two. The `SHARED_CLK` parameter is set when both ports run on one clock. It turns on a same-cycle collision rule that gives port B priority.

Each port runs a small phase machine whose state is the kind of request taken at the last edge. The states are `PS_QUIET` (no request), `PS_READ` (lanes all zero) and `PS_WRITE` (any lane set). Every cycle the machine moves to the state that matches the current request, from any state. The transitions are QUIET, READ or WRITE to QUIET when the request flag is low; any state to READ on a read request; and any state to WRITE on a write request. The output register loads the captured word only in the cycle after a `PS_READ` phase.

Top module: `dp_lane_ram`

## Requirements
- R1: With the request flag high, a lane vector of all zeros is a read, and a nonzero vector writes only the enabled lanes. Lane bit i covers data bits [8*i+7 : 8*i] in the default 32-bit, 4-lane configuration. Disabled lanes keep their stored value.
- R2: During a read request the write-data input has no effect on the stored contents.
- R3: With `OUT_REG`=0, the read word appears on the read-data output right after the first rising edge of that port's clock that follows the request.
- R4: With `OUT_REG`=1, the read word appears after the second rising edge, and after the first edge the output still shows the previous read result.
- R5: The read-data output holds its value until a later read completes. A write on the same port does not change it.
- R6: A write to an address at or above `DEPTH` changes no stored word. A read of such an address returns zero.
- R7: Reset clears the read-data output of its port to zero and leaves the stored contents intact.
- R8: With `SHARED_CLK`=1, when both ports write one address in the same cycle, port B's data wins in each lane that both enable. Each other enabled lane takes its own port's data.
- R9: When one port reads an address in the same cycle the other port writes it, the read returns the contents from before the write.
- R10: With unrelated clock periods on the two ports, a word written through either port is read back correctly through the other.
- R11: A request is accepted in every cycle it is asserted. Back-to-back reads deliver their words in request order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| req_a | input | 1 | Port A request flag |
| lanes_a | input | LANES | Port A lane enables; all zero means read |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write word |
| rdata_a | output | DATA_W | Port A read word |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| req_b | input | 1 | Port B request flag |
| lanes_b | input | LANES | Port B lane enables; all zero means read |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write word |
| rdata_b | output | DATA_W | Port B read word |

## Verification
The two things that can land in one cycle are a request on port A and a request on port B that hit the same word. Two cases matter: both ports writing with lane sets that partly overlap, and one port reading while the other writes. The bench drives both ports with the same address on a shared clock and replays the two requests into its own array model, A first and then B. It expects the overlapping lanes to carry B's data and the reader to see the old word. A second read of the same word then confirms that the write did land.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    // Kind of request a port accepted at its most recent clock edge.
    typedef enum logic [1:0] {
        PS_QUIET = 2'd0,
        PS_READ  = 2'd1,
        PS_WRITE = 2'd2
    } port_phase_e;

endpackage

// File: rtl/dpr_store.sv
// One storage bank: a single synchronous lane-write port and two
// combinational read ports. Addresses at or above DEPTH are inert.
module dpr_store #(
    parameter int DEPTH  = 24,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_q,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_q
);
    localparam int              CHUNK = DATA_W / LANES;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

    logic [DATA_W-1:0] cells [DEPTH];
    logic              wr_hit;

    assign wr_hit = ({1'b0, wr_addr} < LIMIT) && (|wr_lanes);

    always_ff @(posedge clk) begin
        if (wr_hit) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lanes[l]) begin
                    cells[wr_addr][l*CHUNK +: CHUNK] <= wr_word[l*CHUNK +: CHUNK];
                end
            end
        end
    end

    always_comb begin
        rd0_q = ({1'b0, rd0_addr} < LIMIT) ? cells[rd0_addr] : '0;
        rd1_q = ({1'b0, rd1_addr} < LIMIT) ? cells[rd1_addr] : '0;
    end

endmodule

// File: rtl/dpr_port.sv
// Per-port request decode, phase machine and read pipeline.
module dpr_port
    import dpr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LANES   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] cur_word,
    output logic [LANES-1:0]  wr_lanes,
    output logic [DATA_W-1:0] rdata
);
    port_phase_e       phase_q;
    port_phase_e       phase_d;
    logic [DATA_W-1:0] cap_q;

    // Next phase follows the request presented this cycle.
    always_comb begin
        unique case ({req, |lanes})
            2'b10:   phase_d = PS_READ;
            2'b11:   phase_d = PS_WRITE;
            default: phase_d = PS_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PS_QUIET;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Outputs: capture the addressed word on a read; writes pass lanes on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (phase_d == PS_READ) begin
            cap_q <= cur_word;
        end
    end

    assign wr_lanes = (phase_d == PS_WRITE) ? lanes : '0;

    generate
        if (OUT_REG) begin : g_two_stage
            logic [DATA_W-1:0] out_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else if (phase_q == PS_READ) begin
                    out_q <= cap_q;
                end
            end
            assign rdata = out_q;
        end else begin : g_one_stage
            assign rdata = cap_q;
        end
    endgenerate

endmodule

// File: rtl/dp_lane_ram.sv
// Byte-lane dual-port RAM. Storage is two banks whose XOR is the word,
// so each bank has a single writer clock.
module dp_lane_ram #(
    parameter int DEPTH      = 24,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int LANES      = 4,
    parameter bit OUT_REG    = 1'b1,
    parameter bit SHARED_CLK = 1'b1
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              req_a,
    input  logic [LANES-1:0]  lanes_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              req_b,
    input  logic [LANES-1:0]  lanes_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b
);
    // Bank A reads: qa0 at addr_a, qa1 at addr_b; likewise bank B.
    logic [DATA_W-1:0] qa0, qa1, qb0, qb1;
    logic [DATA_W-1:0] word_at_a, word_at_b;
    logic [DATA_W-1:0] enc_a, enc_b;
    logic [LANES-1:0]  wl_a, wl_b, eff_a;

    assign word_at_a = qa0 ^ qb0;
    assign word_at_b = qa1 ^ qb1;
    assign enc_a     = wdata_a ^ qb0;
    assign enc_b     = wdata_b ^ qa1;

    dpr_port #(.DATA_W(DATA_W), .LANES(LANES), .OUT_REG(OUT_REG)) u_port_a (
        .clk(clk_a), .rst_n(rst_a_n), .req(req_a), .lanes(lanes_a),
        .cur_word(word_at_a), .wr_lanes(wl_a), .rdata(rdata_a)
    );

    dpr_port #(.DATA_W(DATA_W), .LANES(LANES), .OUT_REG(OUT_REG)) u_port_b (
        .clk(clk_b), .rst_n(rst_b_n), .req(req_b), .lanes(lanes_b),
        .cur_word(word_at_b), .wr_lanes(wl_b), .rdata(rdata_b)
    );

    // Same-cycle collision on a shared clock: B keeps the shared lanes.
    generate
        if (SHARED_CLK) begin : g_b_priority
            assign eff_a = (addr_a == addr_b) ? (wl_a & ~wl_b) : wl_a;
        end else begin : g_no_arb
            assign eff_a = wl_a;
        end
    endgenerate

    dpr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_bank_a (
        .clk(clk_a), .wr_lanes(eff_a), .wr_addr(addr_a), .wr_word(enc_a),
        .rd0_addr(addr_a), .rd0_q(qa0), .rd1_addr(addr_b), .rd1_q(qa1)
    );

    dpr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_bank_b (
        .clk(clk_b), .wr_lanes(wl_b), .wr_addr(addr_b), .wr_word(enc_b),
        .rd0_addr(addr_a), .rd0_q(qb0), .rd1_addr(addr_b), .rd1_q(qb1)
    );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int DEPTH   = 24,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int LANES   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk_a,
    input logic              rst_a_n,
    input logic              req_a,
    input logic [LANES-1:0]  lanes_a,
    input logic [ADDR_W-1:0] addr_a,
    input logic [DATA_W-1:0] rdata_a,
    input logic              clk_b,
    input logic              rst_b_n,
    input logic              req_b,
    input logic [LANES-1:0]  lanes_b,
    input logic [ADDR_W-1:0] addr_b,
    input logic [DATA_W-1:0] rdata_b
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

    logic rd_a, wr_a, oor_a, rd_b, wr_b, oor_b;
    assign rd_a  = req_a && (lanes_a == '0);
    assign wr_a  = req_a && (lanes_a != '0);
    assign oor_a = ({1'b0, addr_a} >= LIMIT);
    assign rd_b  = req_b && (lanes_b == '0);
    assign wr_b  = req_b && (lanes_b != '0);
    assign oor_b = ({1'b0, addr_b} >= LIMIT);

    AST_A_WRITE_KEEPS_RDATA: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (wr_a && !$past(rd_a)) |=> $stable(rdata_a)); // R5
    AST_B_WRITE_KEEPS_RDATA: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (wr_b && !$past(rd_b)) |=> $stable(rdata_b)); // R5
    AST_A_OOR_ONE: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!OUT_REG && rd_a && oor_a) |=> (rdata_a == '0)); // R6
    AST_A_OOR_TWO: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (OUT_REG && rd_a && oor_a) |=> ##1 (rdata_a == '0)); // R6
    AST_B_OOR_ONE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!OUT_REG && rd_b && oor_b) |=> (rdata_b == '0)); // R6
    AST_B_OOR_TWO: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (OUT_REG && rd_b && oor_b) |=> ##1 (rdata_b == '0)); // R6
    AST_A_RESET_ZERO: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $rose(rst_a_n) |-> (rdata_a == '0)); // R7
    AST_B_RESET_ZERO: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $rose(rst_b_n) |-> (rdata_b == '0)); // R7

endmodule

bind dp_lane_ram dpr_checker #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .OUT_REG(OUT_REG)
) u_chk (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .req_a(req_a), .lanes_a(lanes_a),
    .addr_a(addr_a), .rdata_a(rdata_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .req_b(req_b), .lanes_b(lanes_b),
    .addr_b(addr_b), .rdata_b(rdata_b)
);

// File: tb/sim_dp_lane_ram.sv
`timescale 1ns/1ps
module sim_dp_lane_ram;
    logic clk = 1'b0, clk_s = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;      // 200 MHz
    always #3.5 clk_s = ~clk_s;  // unrelated second clock

    // u0: two-cycle latency, shared clock
    logic a0_req = 0, b0_req = 0;
    logic [3:0] a0_ln = 0, b0_ln = 0;
    logic [4:0] a0_ad = 0, b0_ad = 0;
    logic [31:0] a0_wd = 0, b0_wd = 0, a0_rd, b0_rd;
    // u1: one-cycle latency, separate clocks
    logic a1_req = 0, b1_req = 0;
    logic [3:0] a1_ln = 0, b1_ln = 0;
    logic [4:0] a1_ad = 0, b1_ad = 0;
    logic [31:0] a1_wd = 0, b1_wd = 0, a1_rd, b1_rd;

    dp_lane_ram #(.DEPTH(24), .ADDR_W(5), .DATA_W(32), .LANES(4), .OUT_REG(1'b1), .SHARED_CLK(1'b1)) u0 (
        .clk_a(clk), .rst_a_n(rst_n), .req_a(a0_req), .lanes_a(a0_ln), .addr_a(a0_ad), .wdata_a(a0_wd), .rdata_a(a0_rd),
        .clk_b(clk), .rst_b_n(rst_n), .req_b(b0_req), .lanes_b(b0_ln), .addr_b(b0_ad), .wdata_b(b0_wd), .rdata_b(b0_rd));

    dp_lane_ram #(.DEPTH(24), .ADDR_W(5), .DATA_W(32), .LANES(4), .OUT_REG(1'b0), .SHARED_CLK(1'b0)) u1 (
        .clk_a(clk), .rst_a_n(rst_n), .req_a(a1_req), .lanes_a(a1_ln), .addr_a(a1_ad), .wdata_a(a1_wd), .rdata_a(a1_rd),
        .clk_b(clk_s), .rst_b_n(rst_n), .req_b(b1_req), .lanes_b(b1_ln), .addr_b(b1_ad), .wdata_b(b1_wd), .rdata_b(b1_rd));

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] m0 [24];
    logic [31:0] m1 [24];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] ln);
        for (int i = 0; i < 4; i++) if (ln[i]) o[i*8 +: 8] = n[i*8 +: 8];
        return o;
    endfunction

    function automatic logic [31:0] pat(input int a, input int s);
        return (32'h9E37_79B9 * 32'(a + 1)) ^ (32'h0101_0101 * 32'(s));
    endfunction

    function automatic logic [31:0] look0(input int a);
        return (a < 24) ? m0[a] : 32'h0;
    endfunction

    // One shared-clock cycle on u0; call at a negedge of clk.
    task automatic u0_cyc(input logic ra, input logic [3:0] la, input logic [4:0] aa, input logic [31:0] da,
                          input logic rb, input logic [3:0] lb, input logic [4:0] ab, input logic [31:0] db);
        a0_req = ra; a0_ln = la; a0_ad = aa; a0_wd = da;
        b0_req = rb; b0_ln = lb; b0_ad = ab; b0_wd = db;
        @(negedge clk);
        a0_req = 0; b0_req = 0;
    endtask

    task automatic u1_a(input logic [3:0] ln, input logic [4:0] ad, input logic [31:0] wd);
        @(negedge clk);
        a1_req = 1; a1_ln = ln; a1_ad = ad; a1_wd = wd;
        @(negedge clk);
        a1_req = 0;
    endtask

    task automatic u1_b(input logic [3:0] ln, input logic [4:0] ad, input logic [31:0] wd);
        @(negedge clk_s);
        b1_req = 1; b1_ln = ln; b1_ad = ad; b1_wd = wd;
        @(negedge clk_s);
        b1_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R11 act=incomplete exp=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] old;
        repeat (3) @(negedge clk);
        chk("R7 reset u0 A", a0_rd, 0); chk("R7 reset u0 B", b0_rd, 0);
        chk("R7 reset u1 A", a1_rd, 0); chk("R7 reset u1 B", b1_rd, 0);
        rst_n = 1;
        @(negedge clk);

        // Fill through A, then partial-lane overwrite through B (R1)
        for (int a = 0; a < 24; a++) begin
            u0_cyc(1, 4'hF, 5'(a), pat(a, 1), 0, 0, 0, 0);
            m0[a] = pat(a, 1);
        end
        for (int a = 0; a < 24; a++) begin
            logic [3:0] ln = 4'((a % 15) + 1);
            u0_cyc(0, 0, 0, 0, 1, ln, 5'(a), pat(a, 2));
            m0[a] = merge(m0[a], pat(a, 2), ln);
        end
        // Out-of-range writes ignored (R6)
        u0_cyc(1, 4'hF, 5'd27, 32'hDEAD_BEEF, 1, 4'hF, 5'd24, 32'hCAFE_F00D);
        // Sweep every address on both ports (R1, R6)
        for (int a = 0; a < 32; a++) begin
            u0_cyc(1, 0, 5'(a), 0, 1, 0, 5'(31 - a), 0);
            @(negedge clk);
            chk((a < 24) ? "R1 sweep A" : "R6 oor A", a0_rd, look0(a));
            chk((31 - a < 24) ? "R1 sweep B" : "R6 oor B", b0_rd, look0(31 - a));
        end

        // Two-cycle latency (R4): A last showed addr 31 -> zero
        u0_cyc(1, 0, 5'd7, 0, 0, 0, 0, 0);
        chk("R4 old value after one edge", a0_rd, 32'h0);
        @(negedge clk);
        chk("R4 new value after two edges", a0_rd, m0[7]);

        // Back-to-back reads (R11)
        a0_req = 1; a0_ln = 0; a0_ad = 0;
        @(negedge clk); a0_ad = 1;
        @(negedge clk); chk("R11 stream 0", a0_rd, m0[0]); a0_ad = 2;
        @(negedge clk); chk("R11 stream 1", a0_rd, m0[1]); a0_req = 0;
        @(negedge clk); chk("R11 stream 2", a0_rd, m0[2]);

        // Read ignores write data (R2)
        u0_cyc(1, 0, 5'd3, 32'hFFFF_FFFF, 0, 0, 0, 0);
        @(negedge clk);
        u0_cyc(1, 0, 5'd3, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R2 read left word", a0_rd, m0[3]);

        // Write does not disturb read output (R5)
        u0_cyc(1, 4'hF, 5'd3, 32'h1234_5678, 0, 0, 0, 0);
        chk("R5 hold 1", a0_rd, m0[3]);
        @(negedge clk);
        chk("R5 hold 2", a0_rd, m0[3]);
        m0[3] = 32'h1234_5678;
        u0_cyc(1, 0, 5'd3, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R5 write landed", a0_rd, m0[3]);

        // Double write, overlapping lanes: B wins (R8)
        u0_cyc(1, 4'b0011, 5'd5, 32'hA1A2_A3A4, 1, 4'b0110, 5'd5, 32'hB1B2_B3B4);
        m0[5] = merge(merge(m0[5], 32'hA1A2_A3A4, 4'b0011), 32'hB1B2_B3B4, 4'b0110);
        u0_cyc(0, 0, 0, 0, 1, 0, 5'd5, 0);
        @(negedge clk);
        chk("R8 B priority", b0_rd, m0[5]);

        // Read/write collision returns old contents (R9)
        old = m0[6];
        u0_cyc(1, 0, 5'd6, 0, 1, 4'hF, 5'd6, 32'h5A5A_C3C3);
        m0[6] = 32'h5A5A_C3C3;
        @(negedge clk);
        chk("R9 old contents", a0_rd, old);
        u0_cyc(1, 0, 5'd6, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R9 new contents", a0_rd, m0[6]);

        // Reset mid-run clears outputs, keeps memory (R7)
        rst_n = 0;
        @(negedge clk);
        chk("R7 mid reset A", a0_rd, 0); chk("R7 mid reset B", b0_rd, 0);
        rst_n = 1;
        @(negedge clk); @(negedge clk_s);
        u0_cyc(0, 0, 0, 0, 1, 0, 5'd5, 0);
        @(negedge clk);
        chk("R7 memory kept", b0_rd, m0[5]);

        // u1: unrelated clocks, one-cycle latency (R10, R3)
        for (int a = 0; a < 24; a++) begin
            m1[a] = pat(a, 3);
            if (a % 2 == 0) u1_a(4'hF, 5'(a), m1[a]);
            else            u1_b(4'hF, 5'(a), m1[a]);
        end
        for (int a = 0; a < 24; a += 3) begin
            u1_b(4'b1001, 5'(a), pat(a, 4));
            m1[a] = merge(m1[a], pat(a, 4), 4'b1001);
        end
        for (int a = 0; a < 24; a++) begin
            u1_b(0, 5'(a), 0);
            chk("R10 read via B", b1_rd, m1[a]);
            u1_a(0, 5'(a), 0);
            chk("R3 one-edge read via A", a1_rd, m1[a]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule